// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block supervises the link of a 10 Mb/s twisted-pair port. While the local transmitter is silent, it emits a short idle link pulse at a fixed interval. It also watches two things on the receive side: a strobe that marks each accepted incoming link pulse, and the receive-carrier level. From these it decides whether the link passes or fails.

In the failing state the block withdraws the transmit, receive and collision enables and hides the receive status. A strap input can switch the monitor off. The datapath then stays enabled whatever the link state, and the pulse generator keeps running.

All timers are counted in clock cycles and set by parameters, so a simulation can shrink them. With a 10 MHz clock the defaults are a 16 ms pulse interval, a one-cycle pulse, a 100 ms loss window and a 2 ms minimum spacing between received pulses.

Top module: `lnk_integrity`

## Requirements
- R1: While rstN is low, linkOk, linkPulseOut, txEnable, rxEnable, colEnable and rxStatus are all 0, and the block sits in the failing state.
- R2: With txActive low, linkPulseOut goes high every IDLE_PERIOD cycles. The first rising edge comes IDLE_PERIOD clock edges after reset release, or after the last edge at which txActive was sampled high.
- R3: Each idle pulse on linkPulseOut stays high for exactly PULSE_WIDTH cycles.
- R4: After any clock edge that samples txActive high, linkPulseOut is 0, and the interval count starts again from zero.
- R5: In the failing state, the edge that samples the PASS_RUN-th consecutive valid pulse strobe moves the block to the passing state, and linkOk becomes 1.
- R6: In the failing state, an edge that samples rxCarrier high moves the block to the passing state.
- R7: A pulse strobe that arrives fewer than MIN_SPACING cycles after the previous strobe is early. It does not count, and it clears the run of consecutive pulses; the next strobe counts only when it comes at least MIN_SPACING cycles after the early one.
- R8: In the passing state, the block falls back to failing at the LOSS_LIMIT-th clock edge after the last edge that sampled a pulse strobe or rxCarrier. A strobe or carrier restarts that window.
- R9: txEnable, rxEnable and colEnable are 1 exactly when the block is passing or monitorOff is 1.
- R10: rxStatus equals rxCarrier while the receive path is enabled, and is 0 in the failing state when monitorOff is 0.
- R11: With monitorOff at 1, the idle pulses continue as in R2 and R3 and the enables stay at 1. linkOk still follows the monitor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txActive | input | 1 | Transmit data present on the port |
| rxCarrier | input | 1 | Receive carrier level (valid data) |
| pulseIn | input | 1 | One-cycle strobe per accepted received link pulse |
| monitorOff | input | 1 | Strap: 1 disables link gating |
| linkPulseOut | output | 1 | Request to drive an idle link pulse |
| linkOk | output | 1 | Link passing indicator |
| txEnable | output | 1 | Transmit path enable |
| rxEnable | output | 1 | Receive path enable |
| colEnable | output | 1 | Collision detect enable |
| rxStatus | output | 1 | Gated receive activity status |

## Verification
Several functions can fall in the same cycle. A received pulse strobe can land on the very edge where the loss window would expire, a carrier can arrive together with an early strobe, and a transmit burst can begin while an idle pulse is still high. The random phase draws transmit bursts, carrier bursts, pulse strobes at random spacings and strap flips from a fixed-seed $urandom stream, so these collisions occur many times. Every cycle the outputs are compared with a cycle model written from the requirements. In that model a restart beats expiry, carrier beats an early strobe, and txActive cancels a pulse that is in progress.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_PASS = 1'b1
  } lnkState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clearRun;
    logic countEn;
  } lnkCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic pulseValid;
    logic pulseEarly;
    logic lossExpired;
    logic runFull;
  } lnkEvt_t;
endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
  parameter int IDLE_PERIOD = 160000,
  parameter int PULSE_WIDTH = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic txActive,
  output logic linkPulseOut
);
  localparam int GAP_W = $clog2(IDLE_PERIOD);
  localparam int PW_W  = $clog2(PULSE_WIDTH + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(IDLE_PERIOD - 1);
  localparam logic [PW_W-1:0]  PW_INIT  = PW_W'(PULSE_WIDTH);

  logic [GAP_W-1:0] gapCnt;
  logic [PW_W-1:0]  widthCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      widthCnt <= '0;
    end else if (txActive) begin
      gapCnt   <= '0;
      widthCnt <= '0;
    end else if (gapCnt == GAP_LAST) begin
      gapCnt   <= '0;
      widthCnt <= PW_INIT;
    end else begin
      gapCnt <= gapCnt + 1'b1;
      if (widthCnt != '0) widthCnt <= widthCnt - 1'b1;
    end
  end

  assign linkPulseOut = (widthCnt != '0);

  // R4
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(txActive) |-> !linkPulseOut);

  // R2
  pulse_idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkPulseOut) |-> $past(!txActive));
endmodule

// File: rtl/lnk_datapath.sv
module lnk_datapath
  import lnk_pkg::*;
#(
  parameter int LOSS_LIMIT  = 1000000,
  parameter int MIN_SPACING = 20000,
  parameter int PASS_RUN    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pulseIn,
  input  logic    rxCarrier,
  input  lnkCmd_t cmd,
  output lnkEvt_t evt
);
  localparam int LOSS_W  = $clog2(LOSS_LIMIT);
  localparam int SPACE_W = $clog2(MIN_SPACING + 1);
  localparam int RUN_W   = $clog2(PASS_RUN + 1);
  localparam logic [LOSS_W-1:0]  LOSS_LAST = LOSS_W'(LOSS_LIMIT - 1);
  localparam logic [SPACE_W-1:0] SPACE_MAX = SPACE_W'(MIN_SPACING);
  localparam logic [RUN_W-1:0]   RUN_LAST  = RUN_W'(PASS_RUN - 1);

  logic [LOSS_W-1:0]  lossCnt;
  logic [SPACE_W-1:0] spaceCnt;
  logic [RUN_W-1:0]   runCnt;
  logic               restart;

  assign restart         = pulseIn | rxCarrier;
  assign evt.pulseValid  = pulseIn & (spaceCnt == SPACE_MAX);
  assign evt.pulseEarly  = pulseIn & (spaceCnt != SPACE_MAX);
  assign evt.lossExpired = !restart & (lossCnt == LOSS_LAST);
  assign evt.runFull     = (runCnt == RUN_LAST);

  // spacing since the previous received strobe, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    spaceCnt <= SPACE_MAX;
    else if (pulseIn)             spaceCnt <= SPACE_W'(1);
    else if (spaceCnt != SPACE_MAX) spaceCnt <= spaceCnt + 1'b1;
  end

  // loss window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             lossCnt <= '0;
    else if (restart || evt.lossExpired)   lossCnt <= '0;
    else                                   lossCnt <= lossCnt + 1'b1;
  end

  // consecutive valid pulse run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                runCnt <= '0;
    else if (cmd.clearRun)                    runCnt <= '0;
    else if (cmd.countEn && evt.pulseValid)   runCnt <= runCnt + 1'b1;
  end

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < RUN_W'(PASS_RUN));

  // R7
  back_to_back_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseIn && $past(pulseIn)) |-> evt.pulseEarly);
endmodule

// File: rtl/lnk_ctrl.sv
module lnk_ctrl
  import lnk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxCarrier,
  input  logic    monitorOff,
  input  lnkEvt_t evt,
  output lnkCmd_t cmd,
  output logic    linkOk,
  output logic    pathOn
);
  lnkState_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      LNK_FAIL: if (rxCarrier || (evt.pulseValid && evt.runFull)) nextState = LNK_PASS;
      LNK_PASS: if (evt.lossExpired) nextState = LNK_FAIL;
      default:  nextState = LNK_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LNK_FAIL;
    else       state <= nextState;
  end

  assign cmd.countEn  = (state == LNK_FAIL);
  assign cmd.clearRun = (nextState != state) ||
                        ((state == LNK_FAIL) && (evt.pulseEarly || evt.lossExpired));
  assign linkOk = (state == LNK_PASS);
  assign pathOn = linkOk | monitorOff;

  // R8
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkOk) |-> $past(evt.lossExpired));

  // R5 R6
  pass_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkOk) |-> $past(rxCarrier || (evt.pulseValid && evt.runFull)));
endmodule

// File: rtl/lnk_integrity.sv
module lnk_integrity
  import lnk_pkg::*;
#(
  parameter int IDLE_PERIOD = 160000,
  parameter int PULSE_WIDTH = 1,
  parameter int LOSS_LIMIT  = 1000000,
  parameter int MIN_SPACING = 20000,
  parameter int PASS_RUN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic txActive,
  input  logic rxCarrier,
  input  logic pulseIn,
  input  logic monitorOff,
  output logic linkPulseOut,
  output logic linkOk,
  output logic txEnable,
  output logic rxEnable,
  output logic colEnable,
  output logic rxStatus
);
  lnkCmd_t cmd;
  lnkEvt_t evt;
  logic    pathOn;

  lnk_pulse_gen #(.IDLE_PERIOD(IDLE_PERIOD), .PULSE_WIDTH(PULSE_WIDTH)) gen_i (
    .clk(clk), .rstN(rstN), .txActive(txActive), .linkPulseOut(linkPulseOut));

  lnk_datapath #(.LOSS_LIMIT(LOSS_LIMIT), .MIN_SPACING(MIN_SPACING), .PASS_RUN(PASS_RUN)) dp_i (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .rxCarrier(rxCarrier), .cmd(cmd), .evt(evt));

  lnk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxCarrier(rxCarrier), .monitorOff(monitorOff),
    .evt(evt), .cmd(cmd), .linkOk(linkOk), .pathOn(pathOn));

  assign txEnable  = pathOn;
  assign rxEnable  = pathOn;
  assign colEnable = pathOn;
  assign rxStatus  = rxCarrier & pathOn;

  // R10
  rx_status_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!linkOk && !monitorOff) |-> !rxStatus);
endmodule

// File: tb/lnk_integrity_tb_top.sv
module lnk_integrity_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 40;
  localparam int WIDTH  = 3;
  localparam int LOSS   = 200;
  localparam int SPACE  = 20;
  localparam int RUN    = 3;

  logic clk = 0, rstN = 0;
  logic txActive = 0, rxCarrier = 0, pulseIn = 0, monitorOff = 0;
  logic linkPulseOut, linkOk, txEnable, rxEnable, colEnable, rxStatus;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  int mGap = 0, mPw = 0, mAge = SPACE, mLoss = 0, mRun = 0;
  bit mPass = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_integrity #(.IDLE_PERIOD(PERIOD), .PULSE_WIDTH(WIDTH), .LOSS_LIMIT(LOSS),
                  .MIN_SPACING(SPACE), .PASS_RUN(RUN)) dut_i (
    .clk(clk), .rstN(rstN), .txActive(txActive), .rxCarrier(rxCarrier),
    .pulseIn(pulseIn), .monitorOff(monitorOff), .linkPulseOut(linkPulseOut),
    .linkOk(linkOk), .txEnable(txEnable), .rxEnable(rxEnable),
    .colEnable(colEnable), .rxStatus(rxStatus));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expPath(input bit pass, input bit off);
    return pass | off;
  endfunction

  task automatic modelTick();
    bit valid, early, restart, expired;
    if (txActive) begin mGap = 0; mPw = 0; end
    else if (mGap == PERIOD-1) begin mGap = 0; mPw = WIDTH; end
    else begin mGap++; if (mPw > 0) mPw--; end
    valid   = pulseIn && (mAge >= SPACE);
    early   = pulseIn && !valid;
    restart = pulseIn || rxCarrier;
    expired = !restart && (mLoss == LOSS-1);
    if (!mPass) begin
      if (rxCarrier || (valid && mRun == RUN-1)) begin mPass = 1; mRun = 0; end
      else if (valid) mRun++;
      else if (early || expired) mRun = 0;
    end else if (expired) begin mPass = 0; mRun = 0; end
    mLoss = (restart || expired) ? 0 : mLoss + 1;
    if (pulseIn) mAge = 1; else if (mAge < SPACE) mAge++;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelTick();
    #1;
    chk(linkPulseOut == (mPw != 0), "R3 pulse", linkPulseOut, mPw != 0);
    chk(linkOk == mPass, tag, linkOk, mPass);
    chk(txEnable == expPath(mPass, monitorOff) && rxEnable == txEnable && colEnable == txEnable,
        "R9 enables", txEnable, expPath(mPass, monitorOff));
    chk(rxStatus == (rxCarrier & expPath(mPass, monitorOff)), "R10 rxStatus",
        rxStatus, rxCarrier & expPath(mPass, monitorOff));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic strobe(input string tag);
    pulseIn = 1; step(tag); pulseIn = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int rises, highs, seedv;
    bit prev;
    seedv = $urandom(32'h5EED_0101);
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(!linkOk && !linkPulseOut, "R1 reset link/pulse", linkOk + 2*linkPulseOut, 0);
    chk(!txEnable && !rxEnable && !colEnable && !rxStatus, "R1 reset enables",
        txEnable + rxEnable + colEnable, 0);
    @(negedge clk); rstN = 1;
    #1;
    // R2/R3: two idle periods
    rises = 0; highs = 0; prev = 0;
    for (int i = 0; i < 2*PERIOD; i++) begin
      step("R2 idle");
      if (linkPulseOut && !prev) rises++;
      if (linkPulseOut) highs++;
      prev = linkPulseOut;
    end
    chk(rises == 2, "R2 pulse count", rises, 2);
    chk(highs == WIDTH + 1, "R3 high cycles", highs, WIDTH + 1);
    // R4: transmit suppresses pulses
    txActive = 1; highs = 0;
    for (int i = 0; i < 3*PERIOD; i++) begin step("R4 tx"); if (linkPulseOut) highs++; end
    chk(highs == 0, "R4 no pulse during tx", highs, 0);
    txActive = 0;
    idle(PERIOD - 1, "R4 restart");
    chk(!linkPulseOut, "R4 restart not early", linkPulseOut, 0);
    step("R4 restart");
    chk(linkPulseOut, "R4 restart on time", linkPulseOut, 1);
    // R5: run of valid pulses
    strobe("R5"); idle(49, "R5");
    strobe("R5"); idle(49, "R5");
    chk(!linkOk, "R5 two pulses not enough", linkOk, 0);
    strobe("R5");
    chk(linkOk, "R5 third pulse passes", linkOk, 1);
    // R8: loss window
    idle(LOSS - 1, "R8 hold");
    chk(linkOk, "R8 still passing", linkOk, 1);
    step("R8 expire");
    chk(!linkOk, "R8 fails at window", linkOk, 0);
    // R7: early pulse clears run
    strobe("R7"); idle(49, "R7");
    strobe("R7"); idle(9, "R7");
    strobe("R7 early"); idle(49, "R7");
    strobe("R7"); idle(49, "R7");
    strobe("R7");
    chk(!linkOk, "R7 early cleared run", linkOk, 0);
    idle(49, "R7"); strobe("R7");
    chk(linkOk, "R7 passes after fresh run", linkOk, 1);
    idle(LOSS + 2, "R8 drop");
    chk(!linkOk, "R8 dropped again", linkOk, 0);
    // R10/R6: carrier in fail
    rxCarrier = 1; #1;
    chk(!rxStatus, "R10 suppressed in fail", rxStatus, 0);
    step("R6 carrier");
    chk(linkOk && rxStatus, "R6 carrier passes", linkOk + rxStatus, 2);
    idle(LOSS + 5, "R8 carrier holds");
    chk(linkOk, "R8 carrier restarts window", linkOk, 1);
    rxCarrier = 0;
    idle(LOSS + 2, "R8 drop");
    // R11: strap off
    monitorOff = 1; #1;
    chk(txEnable && rxEnable && colEnable && !linkOk, "R11 enables forced",
        txEnable + rxEnable + colEnable, 3);
    rises = 0; prev = linkPulseOut;
    for (int i = 0; i < 2*PERIOD; i++) begin
      step("R11 off");
      if (linkPulseOut && !prev) rises++;
      prev = linkPulseOut;
    end
    chk(rises == 2, "R11 pulses continue", rises, 2);
    monitorOff = 0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 60 == 0) txActive = !txActive;
      if (rxCarrier) begin if ($urandom % 10 == 0) rxCarrier = 0; end
      else if ($urandom % 150 == 0) rxCarrier = 1;
      if ($urandom % 400 == 0) monitorOff = !monitorOff;
      pulseIn = ($urandom % 25 == 0);
      step("R5 R6 R7 R8 random");
    end
    pulseIn = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule